// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a high-rate input clock for the feedback path of an integer-N frequency synthesizer. A behavioural dual-modulus prescaler runs on the input clock and divides by either 11 or 10. A 9-bit main count and a 4-bit swallow count steer it. In normal mode each output period holds `m_in+1` prescaler cycles. The first `a_in` of them are ÷11 and the rest are ÷10, so the total ratio is 10×(M+1)+A. In bypass mode the prescaler and swallow logic stay idle, and the input is divided by M+1 directly.

The divided output is a pulse one input cycle wide, high on the last cycle of each period. The divider samples its settings only at a period boundary, so a period is never cut short. Illegal settings (M = 0, or A above M+1) raise a flag. The divider still runs with M forced to 1 and A limited to M+1.

The control is a four-state machine:
- `ST_IDLE` is entered under reset. On the first clock edge with reset low it takes the start transition and loads a period.
- `ST_SWALLOW` covers the ÷11 prescaler cycles. Its swallow-done transition goes to `ST_MAIN` when the last ÷11 cycle wraps.
- `ST_MAIN` covers the ÷10 cycles.
- `ST_BYPASS` counts input cycles directly.

From `ST_SWALLOW`, `ST_MAIN` or `ST_BYPASS`, the period-end transition reloads. It picks `ST_BYPASS` if `bypass_in` is high, otherwise `ST_SWALLOW` if the swallow count is nonzero, otherwise `ST_MAIN`.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With `bypass_in` low and legal settings, consecutive `div_pulse` highs are exactly 10×(M+1)+A input cycles apart.
- R2: In a normal-mode period, `mod_sel` is high for exactly the first 11×A input cycles and low for the rest.
- R3: With `bypass_in` high, consecutive pulses are M+1 input cycles apart and `mod_sel` stays low.
- R4: `div_pulse` is high for one input cycle per period, on that period's last cycle.
- R5: Extreme ratios: M=1, A=0 gives 20. M=511, A=15 gives 5135. Bypass with M=1 gives 2.
- R6: A = M+1 is legal. Every prescaler cycle is then ÷11 and `mod_sel` is high for the whole period.
- R7: Changes to `m_in`, `a_in` or `bypass_in` during a period do not change that period's length. They take effect from the next period.
- R8: `bad_cfg` is high, combinationally from the inputs, whenever M = 0 or A > M+1. The divider then runs with M forced to 1 and A limited to the forced M+1.
- R9: While reset is high, `div_pulse` and `mod_sel` are low. A fresh period of N cycles begins after the first rising edge with reset low, so the first pulse is high during the N-th cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| m_in | input | 9 | Main count setting M |
| a_in | input | 4 | Swallow count setting A |
| bypass_in | input | 1 | High selects a direct M+1 divide |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each period |
| mod_sel | output | 1 | High while the prescaler divides by 11 |
| bad_cfg | output | 1 | Illegal setting flag |

## Verification
The divider is run through a table of settings: A = 0, A = 1, mid-range values, A = M+1, both extremes and several bypass cases. Some random legal settings in both modes are added. Period length and the count of `mod_sel` cycles are each measured against the formula. Measuring both separates an error in the ÷11/÷10 split from an error in the main count.

Three directed cases cover the remaining behaviour:
- Changing the settings mid-period separates boundary-only loading from immediate loading.
- Illegal settings show whether the flag and the clamps act on M and on A independently.
- Counting from reset release pins down where the first period starts.

// File: rtl/psd_pkg.sv
package psd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2,
        ST_BYPASS  = 2'd3
    } psd_state_e;
endpackage

// File: rtl/psd_cfg_clamp.sv
module psd_cfg_clamp #(
    parameter int M_W = 9,
    parameter int A_W = 4
) (
    input  logic [M_W-1:0] m_raw,
    input  logic [A_W-1:0] a_raw,
    output logic [M_W-1:0] m_eff,
    output logic [A_W-1:0] a_eff,
    output logic           bad
);
    localparam int LIM_W = M_W + 1;

    logic [LIM_W-1:0] raw_limit;
    logic [LIM_W-1:0] eff_limit;
    logic [LIM_W-1:0] a_wide;

    always_comb begin
        a_wide    = LIM_W'(a_raw);
        raw_limit = LIM_W'(m_raw) + LIM_W'(1);
        m_eff     = (m_raw == '0) ? M_W'(1) : m_raw;
        eff_limit = LIM_W'(m_eff) + LIM_W'(1);
        a_eff     = (a_wide > eff_limit) ? eff_limit[A_W-1:0] : a_raw;
        bad       = (m_raw == '0) || (a_wide > raw_limit);
    end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int PRE_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic next_long,
    output logic wrap
);
    localparam int CW = $clog2(PRE_DIV + 1);
    localparam logic [CW-1:0] LOAD_LONG  = CW'(PRE_DIV);
    localparam logic [CW-1:0] LOAD_SHORT = CW'(PRE_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= next_long ? LOAD_LONG : LOAD_SHORT;
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    assign wrap = (cnt == '0);

    assert_pre_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD_LONG)
        else $error("prescaler count out of range");

    assert_pre_idle_held_R3: assert property (@(posedge clk) disable iff (rst)
        hold |=> wrap)
        else $error("prescaler toggled while held");
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
    parameter int M_W     = 9,
    parameter int A_W     = 4,
    parameter int PRE_DIV = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           bypass_in,
    output logic           div_pulse,
    output logic           mod_sel,
    output logic           bad_cfg
);
    import psd_pkg::*;

    localparam int RW        = M_W + 1;
    localparam int MAX_RATIO = PRE_DIV * (2 ** M_W) + (2 ** A_W) - 1;
    localparam int GW        = $clog2(MAX_RATIO + 2) + 1;

    psd_state_e     state, nxt_state;
    logic [RW-1:0]  main_rem;
    logic [A_W-1:0] swal_rem;
    logic [M_W-1:0] m_eff;
    logic [A_W-1:0] a_eff;
    logic           pre_wrap;
    logic           period_end;
    logic           start;

    psd_cfg_clamp #(.M_W(M_W), .A_W(A_W)) i_clamp (
        .m_raw (m_in),
        .a_raw (a_in),
        .m_eff (m_eff),
        .a_eff (a_eff),
        .bad   (bad_cfg)
    );

    psd_prescaler #(.PRE_DIV(PRE_DIV)) i_pre (
        .clk       (clk),
        .rst       (rst),
        .hold      (nxt_state == ST_BYPASS),
        .next_long (nxt_state == ST_SWALLOW),
        .wrap      (pre_wrap)
    );

    // period end: last input cycle of the last main-count step
    always_comb begin
        period_end = 1'b0;
        unique case (state)
            ST_IDLE:    period_end = 1'b0;
            ST_SWALLOW: period_end = (main_rem == RW'(1)) && pre_wrap;
            ST_MAIN:    period_end = (main_rem == RW'(1)) && pre_wrap;
            ST_BYPASS:  period_end = (main_rem == RW'(1));
        endcase
        start = (state == ST_IDLE) || period_end;
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        if (start) begin
            if (bypass_in)          nxt_state = ST_BYPASS;
            else if (a_eff != '0)   nxt_state = ST_SWALLOW;
            else                    nxt_state = ST_MAIN;
        end else begin
            unique case (state)
                ST_IDLE:    nxt_state = ST_IDLE;
                ST_SWALLOW: nxt_state = (pre_wrap && swal_rem == A_W'(1)) ? ST_MAIN : ST_SWALLOW;
                ST_MAIN:    nxt_state = ST_MAIN;
                ST_BYPASS:  nxt_state = ST_BYPASS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt_state;
    end

    // period counters
    always_ff @(posedge clk) begin
        if (rst) begin
            main_rem <= '0;
            swal_rem <= '0;
        end else if (start) begin
            main_rem <= RW'(m_eff) + RW'(1);
            swal_rem <= bypass_in ? '0 : a_eff;
        end else if (state == ST_BYPASS) begin
            main_rem <= main_rem - RW'(1);
        end else if (pre_wrap) begin
            main_rem <= main_rem - RW'(1);
            if (state == ST_SWALLOW) swal_rem <= swal_rem - A_W'(1);
        end
    end

    // outputs
    always_comb begin
        div_pulse = period_end;
        mod_sel   = (state == ST_SWALLOW);
    end

    // checking
    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
        if (rst)            gap <= '0;
        else if (div_pulse) gap <= GW'(1);
        else                gap <= gap + GW'(1);
    end

    assert_gap_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        gap <= GW'(MAX_RATIO + 1))
        else $error("period longer than maximum ratio");

    assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse)
        else $error("pulse wider than one cycle");

    assert_bypass_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BYPASS) |-> (!mod_sel && pre_wrap))
        else $error("prescaler active in bypass");

    assert_modsel_falls_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_sel) |-> $past(pre_wrap))
        else $error("modulus select dropped mid prescaler cycle");

    assert_swallow_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SWALLOW) |-> (swal_rem != '0))
        else $error("swallow state with empty count");

    assert_clamp_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
        !bad_cfg |-> (m_eff == m_in && a_eff == a_in))
        else $error("legal setting altered by clamp");
endmodule

// File: tb/test_pulse_swallow_divider.sv
module test_pulse_swallow_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] m_in = 9'd1;
    logic [3:0] a_in = 4'd0;
    logic       bypass_in = 1'b0;
    logic       div_pulse, mod_sel, bad_cfg;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    pulse_swallow_divider i_pulse_swallow_divider (
        .clk(clk), .rst(rst), .m_in(m_in), .a_in(a_in), .bypass_in(bypass_in),
        .div_pulse(div_pulse), .mod_sel(mod_sel), .bad_cfg(bad_cfg)
    );

    typedef struct packed { logic [8:0] m; logic [3:0] a; logic byp; } vec_t;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{9'd1,   4'd0,  1'b0},
        '{9'd1,   4'd1,  1'b0},
        '{9'd1,   4'd2,  1'b0},
        '{9'd5,   4'd3,  1'b0},
        '{9'd14,  4'd15, 1'b0},
        '{9'd40,  4'd7,  1'b0},
        '{9'd511, 4'd15, 1'b0},
        '{9'd1,   4'd0,  1'b1},
        '{9'd2,   4'd9,  1'b1},
        '{9'd100, 4'd0,  1'b1},
        '{9'd511, 4'd5,  1'b1},
        '{9'd3,   4'd4,  1'b0}
    };

    function automatic int exp_len(int m, int a, bit byp);
        return byp ? (m + 1) : (10 * (m + 1) + a);
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            summary();
        end
    end

    task automatic sync_pulse();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_pulse && k < 12000);
    endtask

    task automatic measure(output int len, output int hi);
        len = 0;
        hi  = 0;
        do begin
            @(negedge clk);
            len++;
            if (mod_sel) hi++;
        end while (!div_pulse && len < 12000);
    endtask

    task automatic apply(int m, int a, bit byp);
        @(negedge clk);
        m_in      = 9'(m);
        a_in      = 4'(a);
        bypass_in = byp;
    endtask

    task automatic run_case(int m, int a, bit byp, string tag);
        int len, hi, el, eh;
        apply(m, a, byp);
        sync_pulse();
        measure(len, hi);
        el = exp_len(m, a, byp);
        eh = byp ? 0 : 11 * a;
        check(len == el, {tag, " period"}, len, el);
        check(hi == eh, {tag, " mod_sel cycles"}, hi, eh);
        @(negedge clk);
        check(div_pulse == 1'b0, {tag, " R4 pulse width"}, int'(div_pulse), 0);
    endtask

    initial begin
        int len, hi, cnt;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R9 reset div_pulse", int'(div_pulse), 0);
        check(mod_sel == 1'b0, "R9 reset mod_sel", int'(mod_sel), 0);

        // R9: first period after release, M=2 A=1 -> 31
        m_in = 9'd2;
        a_in = 4'd1;
        rst  = 1'b0;
        cnt  = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!div_pulse && cnt < 100);
        check(cnt == 31, "R9 first pulse cycle", cnt, 31);

        // table walk: R1 R2 R3 R5 R6
        for (int i = 0; i < NV; i++) begin
            run_case(int'(VECS[i].m), int'(VECS[i].a), VECS[i].byp,
                     VECS[i].byp ? "R3 R5 table" : "R1 R2 R5 R6 table");
        end

        // random legal settings, both modes
        for (int i = 0; i < 8; i++) begin
            int m = 1 + int'($urandom % 150);
            int a = int'($urandom % 16);
            if (a > m + 1) a = m + 1;
            run_case(m, a, (i % 3) == 2, "R1 R3 random");
        end

        // R6: A = M+1, whole period in divide-by-11
        run_case(14, 15, 1'b0, "R6 A=M+1");

        // R7: mid-period change does not alter current period
        apply(20, 4, 1'b0);
        sync_pulse();
        sync_pulse();
        repeat (5) @(negedge clk);
        m_in = 9'd3;
        a_in = 4'd0;
        bypass_in = 1'b1;
        cnt = 5;
        do begin
            @(negedge clk);
            cnt++;
        end while (!div_pulse && cnt < 12000);
        check(cnt == 214, "R7 current period kept", cnt, 214);
        measure(len, hi);
        check(len == 4, "R7 new setting next period", len, 4);

        // R8: illegal settings flag and clamp
        apply(0, 0, 1'b0);
        #1;
        check(bad_cfg == 1'b1, "R8 flag M=0", int'(bad_cfg), 1);
        sync_pulse();
        measure(len, hi);
        check(len == 20, "R8 M=0 clamped period", len, 20);

        apply(3, 9, 1'b0);
        #1;
        check(bad_cfg == 1'b1, "R8 flag A>M+1", int'(bad_cfg), 1);
        sync_pulse();
        measure(len, hi);
        check(len == 44, "R8 A clamped period", len, 44);
        check(hi == 44, "R8 A clamped mod_sel", hi, 44);

        apply(0, 5, 1'b0);
        sync_pulse();
        measure(len, hi);
        check(len == 22, "R8 both clamped period", len, 22);

        apply(3, 4, 1'b0);
        #1;
        check(bad_cfg == 1'b0, "R8 flag low at A=M+1", int'(bad_cfg), 0);

        // R9: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(div_pulse == 1'b0 && mod_sel == 1'b0, "R9 reset mid-run",
              int'({div_pulse, mod_sel}), 0);

        summary();
    end
endmodule